// File: doc/BRIEF.md
# Two-Wire Register Slave with Set/Clear Addressing

This block is a two-wire serial (I2C) target that runs on a system clock. It gives an external bus master access to a small bank of 8-bit control registers, two 8-bit status inputs and three read-only 16-bit identification words. SCL and SDA are oversampled through synchronizers. The block only ever pulls SDA low; a pad or the bench resolves the open-drain line.

Each writable register has two bus addresses. Writing a one at the even address of the pair sets the matching bit. Writing a one at the odd address clears it. A zero bit at either address leaves the register bit as it was. A write transfer carries a pointer byte and then data bytes. A read transfer uses a repeated start and returns bytes from the current pointer. The pointer moves on by one after every data byte in either direction.

The low bit of the 7-bit target address comes from a strap pin. The pin is sampled on the first clock after reset is released. The register outputs drive other logic in the chip. Interrupt generation is not part of this block.

Top module: `i2c_setclr_regs`

## Requirements
- R1: The 7-bit target address is 0101100 when `addr_strap` is low on the first clock after reset release, and 0101101 when it is high. A transfer to any other address receives no acknowledge, and SDA stays released for the rest of that transfer.
- R2: In a write transfer (R/W bit 0), the first byte after the address loads the register pointer. Each later byte is written at the pointer, and the pointer then increments. Every byte of a write transfer addressed to this target is acknowledged.
- R3: At a set address, each data bit that is 1 sets the matching register bit. Bits that are 0 leave the register unchanged.
- R4: At a clear address, each data bit that is 1 clears the matching register bit. Bits that are 0 leave the register unchanged.
- R5: A set/clear register reads back the same value at its set address and at its clear address.
- R6: Register pairs (set/clear) are: mode 1 at 04h/05h, OTG control at 06h/07h, interrupt latch at 0Ah/0Bh, interrupt enable low at 0Ch/0Dh, interrupt enable high at 0Eh/0Fh, and mode 2 at 12h/13h. Each pair drives its own output port.
- R7: Bit 7 of mode 1 is reserved. It reads 0 and no write can change it. Bits 6..0 of mode 1 are freely writable.
- R8: The identification words read low byte first: 00h=CCh, 01h=04h, 02h=01h, 03h=13h, 14h=10h, 15h=02h.
- R9: Address 08h reads `irq_source_in` and address 10h reads `otg_status_in`. Writes to these addresses, and to any unmapped address, change no register. Unmapped addresses read 00h.
- R10: After a repeated start with R/W=1, the target sends bytes MSB first, starting at the pointer and incrementing after each byte. It releases SDA during the master's acknowledge bit, and it stops sending after a not-acknowledge.
- R11: An active-low asynchronous reset clears all registers and the pointer to 0.
- R12: SDA is only ever pulled low, and only while SCL is low does the pull begin. SDA is released in idle and after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Strap level for target address bit 0 |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| otg_status_in | input | 8 | Status byte read at 10h |
| irq_source_in | input | 8 | Status byte read at 08h |
| mode1_q | output | 8 | Mode 1 register (bit 7 always 0) |
| otg_ctl_q | output | 8 | OTG control register |
| irq_latch_q | output | 8 | Interrupt latch register |
| irq_en_lo_q | output | 8 | Interrupt enable low register |
| irq_en_hi_q | output | 8 | Interrupt enable high register |
| mode2_q | output | 8 | Mode 2 register |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for the master's start and stop edges. Each SCL phase also lasts several system clocks longer than the synchronizer delay, so that each rise and fall is seen once and in order. The bench master keeps to this by holding every SCL quarter-phase for six system clocks and moving SDA only at the quarter points where SCL is low. Random register addresses, data and burst lengths are drawn within that fixed timing, so every transfer stays legal while the data patterns vary.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int DW     = 8;
  localparam int NREG   = 6;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } link_state_t;

  typedef struct packed {
    logic             hit;
    logic             clr;
    logic [IDX_W-1:0] idx;
  } sc_dec_t;

  // map a bus address onto a set/clear slot; the odd address of a pair clears
  function automatic sc_dec_t sc_decode(input logic [7:0] a);
    sc_dec_t d;
    d.hit = 1'b1;
    d.clr = a[0];
    case (a[7:1])
      7'h02:   d.idx = IDX_W'(0);
      7'h03:   d.idx = IDX_W'(1);
      7'h05:   d.idx = IDX_W'(2);
      7'h06:   d.idx = IDX_W'(3);
      7'h07:   d.idx = IDX_W'(4);
      7'h09:   d.idx = IDX_W'(5);
      default: begin
        d.idx = '0;
        d.hit = 1'b0;
      end
    endcase
    return d;
  endfunction

  // writable bits of each slot; slot 0 keeps its top bit reserved
  function automatic logic [DW-1:0] slot_mask(input int slot);
    return (slot == 0) ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic [DW-1:0] sc_apply(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] data,
                                             input logic          clr,
                                             input logic [DW-1:0] mask);
    logic [DW-1:0] m;
    m = data & mask;
    return clr ? (cur & ~m) : (cur | m);
  endfunction

  // constant identification bytes, low byte of each word first
  function automatic logic [DW-1:0] id_byte(input logic [7:0] a);
    case (a)
      8'h00:   return 8'hCC;
      8'h01:   return 8'h04;
      8'h02:   return 8'h01;
      8'h03:   return 8'h13;
      8'h14:   return 8'h10;
      8'h15:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic addr_match(input logic [7:0] rx, input logic [6:0] mine);
    return rx[7:1] == mine;
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] line;
  logic [NLINE-1:0] line_d;

  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign line[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d <= '1;
    else        line_d <= line;
  end

  assign scl_s     = line[0];
  assign sda_s     = line[1];
  assign scl_rise  =  line[0] & ~line_d[0];
  assign scl_fall  = ~line[0] &  line_d[0];
  assign start_det =  line[0] &  line_d[0] & ~line[1] &  line_d[1];
  assign stop_det  =  line[0] &  line_d[0] &  line[1] & ~line_d[1];

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
  import i2cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [6:0]    dev_addr,
  input  logic [DW-1:0] rd_data,
  output logic          sda_pull_low,
  output logic          ptr_load,
  output logic          wr_en,
  output logic          rd_adv,
  output logic [DW-1:0] wr_byte
);

  link_state_t   state;
  logic [3:0]    bit_cnt;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic          rw_bit;
  logic          ptr_phase;
  logic          nack_seen;
  logic          byte_done;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      rw_bit       <= 1'b0;
      ptr_phase    <= 1'b0;
      nack_seen    <= 1'b0;
      sda_pull_low <= 1'b0;
      ptr_load     <= 1'b0;
      wr_en        <= 1'b0;
      rd_adv       <= 1'b0;
      wr_byte      <= '0;
    end else begin
      ptr_load <= 1'b0;
      wr_en    <= 1'b0;
      rd_adv   <= 1'b0;
      if (stop_det) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else if (start_det) begin
        state        <= ST_ADDR;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[DW-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              if (addr_match(rx_sh, dev_addr)) begin
                sda_pull_low <= 1'b1;
                rw_bit       <= rx_sh[0];
                state        <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_bit) begin
                tx_sh        <= rd_data;
                sda_pull_low <= ~rd_data[DW-1];
                state        <= ST_RD;
              end else begin
                sda_pull_low <= 1'b0;
                ptr_phase    <= 1'b1;
                state        <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[DW-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              wr_byte      <= rx_sh;
              ptr_load     <= ptr_phase;
              wr_en        <= ~ptr_phase;
              ptr_phase    <= 1'b0;
              sda_pull_low <= 1'b1;
              state        <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              bit_cnt      <= '0;
              state        <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              sda_pull_low <= 1'b0;
              rd_adv       <= 1'b1;
              state        <= ST_RD_ACK;
            end else if (scl_fall) begin
              tx_sh        <= {tx_sh[DW-2:0], 1'b0};
              sda_pull_low <= ~tx_sh[DW-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_seen <= sda_s;
            end else if (scl_fall) begin
              if (nack_seen) begin
                state <= ST_IDLE;
              end else begin
                tx_sh        <= rd_data;
                sda_pull_low <= ~rd_data[DW-1];
                bit_cnt      <= '0;
                state        <= ST_RD;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_low);                                  // R12
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull_low);                      // R12
  AST_PULL_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);                                        // R12
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> (state == ST_ADDR));                         // R10
  AST_MASTER_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK) |-> !sda_pull_low);                                // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_load, wr_en, rd_adv}));                                   // R2

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ptr_load,
  input  logic                    wr_en,
  input  logic                    rd_adv,
  input  logic [DW-1:0]           wr_byte,
  input  logic [DW-1:0]           otg_status_in,
  input  logic [DW-1:0]           irq_source_in,
  output logic [DW-1:0]           rd_data,
  output logic [NREG-1:0][DW-1:0] reg_q
);

  logic [7:0]    ptr;
  logic [DW-1:0] regs [NREG];
  sc_dec_t       dec;

  assign dec = sc_decode(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr <= '0;
    else if (ptr_load)         ptr <= wr_byte;
    else if (wr_en || rd_adv)  ptr <= ptr + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && dec.hit) begin
      for (int i = 0; i < NREG; i++)
        if (dec.idx == IDX_W'(i))
          regs[i] <= sc_apply(regs[i], wr_byte, dec.clr, slot_mask(i));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_q[g] = regs[g];
  end

  always_comb begin
    rd_data = id_byte(ptr);
    if (ptr == 8'h08) rd_data = irq_source_in;
    if (ptr == 8'h10) rd_data = otg_status_in;
    for (int i = 0; i < NREG; i++)
      if (dec.hit && dec.idx == IDX_W'(i)) rd_data = regs[i];
  end

  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_adv) |=> ptr == $past(ptr) + 8'd1);                        // R2
  AST_SET_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.hit && !dec.clr) |=> ($past(reg_q) & ~reg_q) == '0);      // R3
  AST_CLR_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.hit && dec.clr) |=> (reg_q & ~$past(reg_q)) == '0);       // R4
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dec.hit) |=> $stable(reg_q));                                // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[0][DW-1]);                                                       // R7

endmodule

// File: rtl/i2c_setclr_regs.sv
module i2c_setclr_regs
  import i2cs_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h2C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_strap,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull_low,
  input  logic [DW-1:0] otg_status_in,
  input  logic [DW-1:0] irq_source_in,
  output logic [DW-1:0] mode1_q,
  output logic [DW-1:0] otg_ctl_q,
  output logic [DW-1:0] irq_latch_q,
  output logic [DW-1:0] irq_en_lo_q,
  output logic [DW-1:0] irq_en_hi_q,
  output logic [DW-1:0] mode2_q
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic strap_q, strap_lock;
  logic [6:0] dev_addr;
  logic ptr_load, wr_en, rd_adv;
  logic [DW-1:0] wr_byte, rd_data;
  logic [NREG-1:0][DW-1:0] reg_q;

  // strap captured once, on the first clock after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= 1'b0;
      strap_lock <= 1'b0;
    end else if (!strap_lock) begin
      strap_q    <= addr_strap;
      strap_lock <= 1'b1;
    end
  end

  assign dev_addr = {ADDR_BASE[6:1], strap_q};

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .dev_addr(dev_addr), .rd_data(rd_data),
    .sda_pull_low(sda_pull_low), .ptr_load(ptr_load), .wr_en(wr_en),
    .rd_adv(rd_adv), .wr_byte(wr_byte)
  );

  i2cs_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_en(wr_en),
    .rd_adv(rd_adv), .wr_byte(wr_byte), .otg_status_in(otg_status_in),
    .irq_source_in(irq_source_in), .rd_data(rd_data), .reg_q(reg_q)
  );

  assign mode1_q     = reg_q[0];
  assign otg_ctl_q   = reg_q[1];
  assign irq_latch_q = reg_q[2];
  assign irq_en_lo_q = reg_q[3];
  assign irq_en_hi_q = reg_q[4];
  assign mode2_q     = reg_q[5];

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_lock && $past(strap_lock)) |-> $stable(strap_q));                // R1

endmodule

// File: tb/i2c_setclr_regs_test.sv
module i2c_setclr_regs_test;

  localparam int QTR = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_strap = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull_low;
  logic [7:0] otg_status_in = 8'h00;
  logic [7:0] irq_source_in = 8'h00;
  logic [7:0] mode1_q, otg_ctl_q, irq_latch_q, irq_en_lo_q, irq_en_hi_q, mode2_q;
  logic       sda_bus;

  int total = 0;
  int bad   = 0;
  logic [7:0] mreg [6];
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];
  logic [6:0] my_addr = 7'h2C;

  assign sda_bus = sda_m & ~sda_pull_low;

  always #10 clk = ~clk;

  i2c_setclr_regs uut (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .scl_in(scl_m),
    .sda_in(sda_bus), .sda_pull_low(sda_pull_low),
    .otg_status_in(otg_status_in), .irq_source_in(irq_source_in),
    .mode1_q(mode1_q), .otg_ctl_q(otg_ctl_q), .irq_latch_q(irq_latch_q),
    .irq_en_lo_q(irq_en_lo_q), .irq_en_hi_q(irq_en_hi_q), .mode2_q(mode2_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // bench view of the register map
  function automatic int slot_of(input logic [7:0] a);
    case (a)
      8'h04, 8'h05: return 0;
      8'h06, 8'h07: return 1;
      8'h0A, 8'h0B: return 2;
      8'h0C, 8'h0D: return 3;
      8'h0E, 8'h0F: return 4;
      8'h12, 8'h13: return 5;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int s;
    s = slot_of(a);
    if (s >= 0) return mreg[s];
    case (a)
      8'h00: return 8'hCC;  8'h01: return 8'h04;
      8'h02: return 8'h01;  8'h03: return 8'h13;
      8'h14: return 8'h10;  8'h15: return 8'h02;
      8'h08: return irq_source_in;
      8'h10: return otg_status_in;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int s;
    logic [7:0] m;
    s = slot_of(a);
    if (s >= 0) begin
      m = (s == 0) ? (d & 8'h7F) : d;
      if (a[0]) mreg[s] = mreg[s] & ~m;
      else      mreg[s] = mreg[s] | m;
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " mode1"}, mode1_q,     mreg[0]);
    chk({req, " otg"},   otg_ctl_q,   mreg[1]);
    chk({req, " latch"}, irq_latch_q, mreg[2]);
    chk({req, " enlo"},  irq_en_lo_q, mreg[3]);
    chk({req, " enhi"},  irq_en_hi_q, mreg[4]);
    chk({req, " mode2"}, mode2_q,     mreg[5]);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b1; tick(QTR);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(QTR);
    scl_m = 1'b1; tick(2 * QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    b = sda_bus;  tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nak);
  endtask

  task automatic get_byte(input logic nak, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nak);
  endtask

  task automatic wr_txn(input logic [7:0] ptr, input int n);
    logic nak;
    bus_start();
    put_byte({my_addr, 1'b0}, nak); chk("R1 addr ack", {7'd0, nak}, 8'd0);
    put_byte(ptr, nak);             chk("R2 ptr ack",  {7'd0, nak}, 8'd0);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], nak);       chk("R2 data ack", {7'd0, nak}, 8'd0);
      model_write(ptr + 8'(k), wbuf[k]);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] ptr, input int n);
    logic nak;
    bus_start();
    put_byte({my_addr, 1'b0}, nak);
    put_byte(ptr, nak);
    bus_start();
    put_byte({my_addr, 1'b1}, nak); chk("R10 read addr ack", {7'd0, nak}, 8'd0);
    for (int k = 0; k < n; k++) get_byte(k == n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic read_check(input string req, input logic [7:0] ptr, input int n);
    rd_txn(ptr, n);
    for (int k = 0; k < n; k++) chk(req, rbuf[k], model_read(ptr + 8'(k)));
  endtask

  task automatic do_reset(input logic strap);
    addr_strap = strap;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    for (int i = 0; i < 6; i++) mreg[i] = 8'h00;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic nak;
    logic [7:0] a;
    int n;
    void'($urandom(32'h1301));
    do_reset(1'b0);

    // R11 reset state at the ports and pointer at zero
    check_outputs("R11");
    read_check("R11 ptr0 R8", 8'h00, 4);

    // R1 foreign address gets no acknowledge
    bus_start();
    put_byte({7'h2D, 1'b0}, nak);
    chk("R1 foreign nack", {7'd0, nak}, 8'd1);
    put_byte(8'h04, nak);
    chk("R1 stays released", {7'd0, nak}, 8'd1);
    bus_stop();

    // R8 identification words
    read_check("R8 id", 8'h00, 4);
    read_check("R8 id", 8'h14, 2);

    // R9 status inputs, unmapped reads
    otg_status_in = 8'h5A;
    irq_source_in = 8'hC3;
    read_check("R9 status", 8'h08, 2);
    read_check("R9 status", 8'h10, 1);
    read_check("R9 unmapped", 8'h20, 2);

    // R9 writes to read-only and unmapped addresses change nothing
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    wr_txn(8'h08, 2);
    wr_txn(8'h10, 1);
    check_outputs("R9 ro write");
    read_check("R9 ro after", 8'h08, 1);

    // R7 reserved bit of mode 1
    wbuf[0] = 8'hFF;
    wr_txn(8'h04, 1);
    chk("R7 mode1 reserved", mode1_q, 8'h7F);
    read_check("R7 readback", 8'h04, 2);
    wbuf[0] = 8'h80;
    wr_txn(8'h05, 1);
    chk("R7 clear reserved noop", mode1_q, 8'h7F);

    // R6 R3 R4 directed: each pair steers its own port
    wbuf[0] = 8'hA5; wbuf[1] = 8'h00; wbuf[2] = 8'h3C;
    wr_txn(8'h06, 1);
    wr_txn(8'h0A, 1);
    wbuf[0] = 8'h0F;
    wr_txn(8'h0B, 1);
    wbuf[0] = 8'h11;
    wr_txn(8'h0C, 1);
    wr_txn(8'h0E, 1);
    wr_txn(8'h12, 1);
    check_outputs("R6");

    // R10 burst read across several pairs
    read_check("R10 burst", 8'h04, 8);

    // random set/clear traffic: R2 R3 R4 R5
    for (int it = 0; it < 28; it++) begin
      case ($urandom % 6)
        0: a = 8'h04; 1: a = 8'h06; 2: a = 8'h0A;
        3: a = 8'h0C; 4: a = 8'h0E; default: a = 8'h12;
      endcase
      a = a | 8'($urandom % 2);
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(a, n);
      check_outputs("R3 R4");
      read_check("R5 set/clear readback", a & 8'hFE, 2);
    end

    // R11 R1 reset with the strap high moves the address
    do_reset(1'b1);
    check_outputs("R11 second reset");
    bus_start();
    put_byte({7'h2C, 1'b0}, nak);
    chk("R1 strap high old addr", {7'd0, nak}, 8'd1);
    bus_stop();
    my_addr = 7'h2D;
    wbuf[0] = 8'h42;
    wr_txn(8'h13, 1);
    wbuf[0] = 8'h42;
    wr_txn(8'h12, 1);
    chk("R1 strap high write", mode2_q, 8'h42);
    read_check("R1 strap high read", 8'h12, 1);

    finish_run();
  end

endmodule